// File: doc/BRIEF.md
# Receive Descriptor Ownership Sequencer

This block steers one network receive path through a ring of buffer descriptors held in a small descriptor memory. When the receive FIFO reports data for an accepted frame, the block checks that the host has handed over the current descriptor, and then the one after it. It pops frame bytes and counts them against the programmed buffer length. When a buffer fills and the following descriptor is owned, the frame chains into that buffer. The block then gives descriptors back to the host by clearing their ownership bit. When no buffer is available at all, the frame is dropped and counted as missed.

Each descriptor is one 32-bit word. Bit 31 is the ownership flag, where 1 means the block owns the buffer. Bit 30 marks end of packet. Bit 29 reports a buffer error and bit 28 an overflow error. Bits 15:0 hold a byte count. Reads from the descriptor memory are combinational. A write either replaces the whole word or, when `desc_own_only` is high, changes bit 31 alone. Ownership results are kept in a small cache, so a descriptor already known to be owned is not read again.

The controller has twelve states:
- `ST_IDLE` waits for FIFO data.
- `ST_POLL_CUR` reads the current descriptor.
- `ST_POLL_FINAL` repeats that read once.
- `ST_SKIP` discards a missed frame.
- `ST_POLL_NEXT` reads the next descriptor.
- `ST_RECV` pops bytes into the current buffer.
- `ST_HANDOFF` releases a filled buffer by writing its ownership bit only.
- `ST_LOOKAHEAD` reads the descriptor after the new current one.
- `ST_BUFERR` writes error status.
- `ST_DRAIN` discards the rest of a frame that lost its buffer.
- `ST_CLOSE` writes the end-of-packet status.
- `ST_ADVANCE` moves to the next ring slot.

The transitions are:
- `ST_IDLE` goes to `ST_POLL_CUR` when the current descriptor is not cached as owned. It goes to `ST_POLL_NEXT` when only the current one is cached. It goes to `ST_RECV` when no read is needed.
- `ST_POLL_CUR` goes to `ST_POLL_FINAL` if the descriptor is not owned. `ST_POLL_FINAL` goes to `ST_SKIP` if it is still not owned.
- An owned result in either poll state leads to `ST_POLL_NEXT`, or to `ST_RECV` for a ring of one entry. `ST_POLL_NEXT` goes to `ST_RECV`.
- From `ST_RECV`, the last byte leads to `ST_CLOSE`. A full buffer leads to `ST_HANDOFF` when the next descriptor is owned, and to `ST_BUFERR` otherwise.
- `ST_HANDOFF` goes to `ST_LOOKAHEAD`, which returns to `ST_RECV`.
- `ST_BUFERR` goes to `ST_DRAIN`. `ST_DRAIN` and `ST_CLOSE` go to `ST_ADVANCE`.
- `ST_ADVANCE` and `ST_SKIP` return to `ST_IDLE`, the latter after the last byte.

Top module: `rxd_own_sequencer`

## Requirements
- R1: After reset, `miss_count` is 0, `miss_flag` is 0, no pop, read or write is issued while `fifo_avail` is low, and the first frame uses ring index 0.
- R2: When a frame starts and the current descriptor's bit 31 reads 0, the block reads the same descriptor once more on the next cycle. If bit 31 is then 1, the frame is received normally and no miss is counted.
- R3: If both reads show bit 31 as 0, `miss_flag` is set and `miss_count` rises by one. Every byte of the frame is popped and discarded, and no descriptor is read or written until the last byte has been popped. The current index is unchanged.
- R4: When the last byte is popped, the current descriptor is written with bit 31 = 0, bit 30 = 1, bits 29:28 = 0 and bits 15:0 = the total frame length in bytes. The index then advances.
- R5: When a non-last byte fills a buffer (length `buf_len`) and the next descriptor is owned, the current descriptor is written with `desc_own_only` high and bit 31 = 0. The block then reads the descriptor one further along and continues the frame in the next buffer.
- R6: When a non-last byte fills a buffer and the next descriptor is not owned, the current descriptor is written with bit 31 = 0, bits 29 and 28 = 1, and bits 15:0 = the bytes stored. The remaining bytes are discarded and the index advances.
- R7: With `ring_len` = 1, no descriptor other than index 0 is ever read, and a full buffer always takes the error path of R6.
- R8: A descriptor that was cached as owned is not read again before it is used as the current descriptor.
- R9: `miss_count` saturates at its maximum value.
- R10: A high `miss_clr` clears both `miss_count` and `miss_flag` on the next cycle, and takes priority over a miss in the same cycle.
- R11: The index after `ring_len`-1 is 0, and every descriptor access addresses an index below `ring_len`.
- R12: `fifo_pop` is high only while `fifo_avail` is high, and during reception it follows `fifo_avail` each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len | input | IDX_W+1 | Number of ring entries, from 1 to 2^IDX_W |
| buf_len | input | LEN_W | Bytes per receive buffer, at least 1 |
| fifo_avail | input | 1 | Receive FIFO holds a byte of an accepted frame |
| fifo_last | input | 1 | The offered byte is the last of its frame |
| fifo_pop | output | 1 | Take the offered byte this cycle |
| desc_addr | output | IDX_W | Descriptor index for a read or write |
| desc_rd | output | 1 | Descriptor read this cycle |
| desc_rdata | input | 32 | Combinational read data |
| desc_we | output | 1 | Descriptor write |
| desc_own_only | output | 1 | The write changes bit 31 only |
| desc_wdata | output | 32 | Write data |
| miss_clr | input | 1 | Host read strobe that clears the miss state |
| miss_flag | output | 1 | Sticky missed-frame flag |
| miss_count | output | MISS_W | Saturating missed-frame counter |

## Verification
The bench builds the block with IDX_W = 4, LEN_W = 8 and MISS_W = 4. A four-byte buffer makes every chaining and buffer-error path reachable with frames of ten bytes or fewer. A four-bit miss counter can be driven into saturation with seventeen one-byte missed frames. Ring lengths of 1, 2 and 4 are set through the input to cover the single-entry case and the wrap to index 0.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int DESC_W   = 32;
    localparam int COUNT_W  = 16;
    localparam int OWN_BIT  = 31;
    localparam int EOP_BIT  = 30;
    localparam int BERR_BIT = 29;
    localparam int OVF_BIT  = 28;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_CUR,
        ST_POLL_FINAL,
        ST_SKIP,
        ST_POLL_NEXT,
        ST_RECV,
        ST_HANDOFF,
        ST_LOOKAHEAD,
        ST_BUFERR,
        ST_DRAIN,
        ST_CLOSE,
        ST_ADVANCE
    } rx_state_e;

    function automatic logic [DESC_W-1:0] make_status(
        input logic eop,
        input logic berr,
        input logic ovf,
        input logic [COUNT_W-1:0] cnt
    );
        logic [DESC_W-1:0] w;
        w           = '0;
        w[EOP_BIT]  = eop;
        w[BERR_BIT] = berr;
        w[OVF_BIT]  = ovf;
        w[COUNT_W-1:0] = cnt;
        return w;
    endfunction

endpackage

// File: rtl/rxd_ring_step.sv
module rxd_ring_step #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W:0]   ring_len,
    output logic [IDX_W-1:0] idx_next
);
    logic [IDX_W:0] bumped;

    always_comb begin
        bumped = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
        if (bumped >= ring_len) begin
            idx_next = '0;
        end else begin
            idx_next = bumped[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/rxd_miss_counter.sv
module rxd_miss_counter #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_inc,
    input  logic              miss_clr,
    output logic [MISS_W-1:0] miss_count,
    output logic              miss_flag
);
    localparam logic [MISS_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_count <= '0;
            miss_flag  <= 1'b0;
        end else if (miss_clr) begin
            miss_count <= '0;
            miss_flag  <= 1'b0;
        end else if (miss_inc) begin
            miss_flag <= 1'b1;
            if (miss_count != CNT_MAX) begin
                miss_count <= miss_count + 1'b1;
            end
        end
    end

    assert_miss_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == CNT_MAX && !miss_clr) |=> miss_count == CNT_MAX);

    assert_miss_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_clr |=> (miss_count == '0 && !miss_flag));

    assert_miss_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_inc && !miss_clr && miss_count != CNT_MAX)
            |=> (miss_count == $past(miss_count) + 1'b1 && miss_flag));
endmodule

// File: rtl/rxd_byte_tally.sv
module rxd_byte_tally #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_frame,
    input  logic             clr_buf,
    input  logic             cnt_en,
    output logic [LEN_W-1:0] buf_cnt,
    output logic [CNT_W-1:0] frame_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_frame) begin
            buf_cnt   <= '0;
            frame_cnt <= '0;
        end else begin
            if (clr_buf) begin
                buf_cnt <= '0;
            end else if (cnt_en) begin
                buf_cnt <= buf_cnt + 1'b1;
            end
            if (cnt_en) begin
                frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxd_own_sequencer.sv
module rxd_own_sequencer
    import rxd_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int LEN_W  = 12,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W:0]    ring_len,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic              fifo_avail,
    input  logic              fifo_last,
    output logic              fifo_pop,
    output logic [IDX_W-1:0]  desc_addr,
    output logic              desc_rd,
    input  logic [31:0]       desc_rdata,
    output logic              desc_we,
    output logic              desc_own_only,
    output logic [31:0]       desc_wdata,
    input  logic              miss_clr,
    output logic              miss_flag,
    output logic [MISS_W-1:0] miss_count
);
    localparam logic [IDX_W:0] ONE_ENTRY = {{IDX_W{1'b0}}, 1'b1};

    rx_state_e        state, state_nx;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic             cur_known, nxt_known;
    logic             own_rd, multi, buf_full, miss_inc;
    logic             cnt_en, clr_frame, clr_buf;
    logic [LEN_W-1:0] buf_cnt;
    logic [COUNT_W-1:0] frame_cnt;
    logic [LEN_W:0]   fill_next;

    rxd_ring_step #(.IDX_W(IDX_W)) u_step (
        .idx      (cur_idx),
        .ring_len (ring_len),
        .idx_next (nxt_idx)
    );

    rxd_byte_tally #(.LEN_W(LEN_W), .CNT_W(COUNT_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_frame (clr_frame),
        .clr_buf   (clr_buf),
        .cnt_en    (cnt_en),
        .buf_cnt   (buf_cnt),
        .frame_cnt (frame_cnt)
    );

    rxd_miss_counter #(.MISS_W(MISS_W)) u_miss (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_inc   (miss_inc),
        .miss_clr   (miss_clr),
        .miss_count (miss_count),
        .miss_flag  (miss_flag)
    );

    assign own_rd    = desc_rdata[OWN_BIT];
    assign multi     = (ring_len > ONE_ENTRY);
    assign fill_next = {1'b0, buf_cnt} + {{LEN_W{1'b0}}, 1'b1};
    assign buf_full  = (fill_next == {1'b0, buf_len});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Ownership cache and ring position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_known <= 1'b0;
            nxt_known <= 1'b0;
        end else begin
            unique case (state)
                ST_POLL_CUR, ST_POLL_FINAL: begin
                    if (own_rd) cur_known <= 1'b1;
                end
                ST_POLL_NEXT, ST_LOOKAHEAD: begin
                    nxt_known <= own_rd;
                end
                ST_HANDOFF: begin
                    cur_idx   <= nxt_idx;
                    cur_known <= 1'b1;
                    nxt_known <= 1'b0;
                end
                ST_ADVANCE: begin
                    cur_idx   <= nxt_idx;
                    cur_known <= nxt_known & multi;
                    nxt_known <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx      = state;
        fifo_pop      = 1'b0;
        desc_addr     = cur_idx;
        desc_rd       = 1'b0;
        desc_we       = 1'b0;
        desc_own_only = 1'b0;
        desc_wdata    = '0;
        miss_inc      = 1'b0;
        cnt_en        = 1'b0;
        clr_frame     = 1'b0;
        clr_buf       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clr_frame = 1'b1;
                if (fifo_avail) begin
                    if (!cur_known)                    state_nx = ST_POLL_CUR;
                    else if (multi && !nxt_known)      state_nx = ST_POLL_NEXT;
                    else                               state_nx = ST_RECV;
                end
            end
            ST_POLL_CUR: begin
                desc_rd = 1'b1;
                if (!own_rd)     state_nx = ST_POLL_FINAL;
                else if (multi)  state_nx = ST_POLL_NEXT;
                else             state_nx = ST_RECV;
            end
            ST_POLL_FINAL: begin
                desc_rd = 1'b1;
                if (!own_rd) begin
                    miss_inc = 1'b1;
                    state_nx = ST_SKIP;
                end else if (multi) begin
                    state_nx = ST_POLL_NEXT;
                end else begin
                    state_nx = ST_RECV;
                end
            end
            ST_SKIP: begin
                fifo_pop = fifo_avail;
                if (fifo_avail && fifo_last) state_nx = ST_IDLE;
            end
            ST_POLL_NEXT: begin
                desc_rd   = 1'b1;
                desc_addr = nxt_idx;
                state_nx  = ST_RECV;
            end
            ST_RECV: begin
                fifo_pop = fifo_avail;
                cnt_en   = fifo_avail;
                if (fifo_avail) begin
                    if (fifo_last) begin
                        state_nx = ST_CLOSE;
                    end else if (buf_full) begin
                        state_nx = (nxt_known && multi) ? ST_HANDOFF : ST_BUFERR;
                    end
                end
            end
            ST_HANDOFF: begin
                desc_we       = 1'b1;
                desc_own_only = 1'b1;
                clr_buf       = 1'b1;
                state_nx      = ST_LOOKAHEAD;
            end
            ST_LOOKAHEAD: begin
                desc_rd   = 1'b1;
                desc_addr = nxt_idx;
                state_nx  = ST_RECV;
            end
            ST_BUFERR: begin
                desc_we    = 1'b1;
                desc_wdata = make_status(1'b0, 1'b1, 1'b1, frame_cnt);
                state_nx   = ST_DRAIN;
            end
            ST_DRAIN: begin
                fifo_pop = fifo_avail;
                if (fifo_avail && fifo_last) state_nx = ST_ADVANCE;
            end
            ST_CLOSE: begin
                desc_we    = 1'b1;
                desc_wdata = make_status(1'b1, 1'b0, 1'b0, frame_cnt);
                state_nx   = ST_ADVANCE;
            end
            ST_ADVANCE: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assert_pop_needs_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_avail);

    assert_addr_in_ring_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_rd || desc_we) |-> ({1'b0, desc_addr} < ring_len));

    assert_final_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_FINAL) |-> ($past(desc_rd) && $past(desc_addr) == desc_addr));

    assert_no_poll_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_inc |=> !desc_rd);

    assert_release_clears_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> !desc_wdata[OWN_BIT]);

    assert_handoff_lookahead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && desc_own_only) |=> desc_rd);

    assert_single_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_rd && ring_len == ONE_ENTRY) |-> desc_addr == '0);
endmodule

// File: tb/rxd_own_sequencer_tb.sv
module rxd_own_sequencer_tb;
    localparam int IDX_W  = 4;
    localparam int LEN_W  = 8;
    localparam int MISS_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W:0]    ring_len = 5'd4;
    logic [LEN_W-1:0]  buf_len = 8'd4;
    logic              fifo_avail = 1'b0;
    logic              fifo_last = 1'b0;
    logic              fifo_pop;
    logic [IDX_W-1:0]  desc_addr;
    logic              desc_rd;
    logic [31:0]       desc_rdata;
    logic              desc_we;
    logic              desc_own_only;
    logic [31:0]       desc_wdata;
    logic              miss_clr = 1'b0;
    logic              miss_flag;
    logic [MISS_W-1:0] miss_count;

    logic [31:0] mem [16];
    int          rd_cnt [16];
    int          wr_cnt;
    logic        late_en = 1'b0;
    logic [3:0]  late_idx = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          bad_pop = 0;

    always #5 clk = ~clk;

    rxd_own_sequencer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .MISS_W(MISS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_len(ring_len), .buf_len(buf_len),
        .fifo_avail(fifo_avail), .fifo_last(fifo_last), .fifo_pop(fifo_pop),
        .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_rdata(desc_rdata),
        .desc_we(desc_we), .desc_own_only(desc_own_only), .desc_wdata(desc_wdata),
        .miss_clr(miss_clr), .miss_flag(miss_flag), .miss_count(miss_count)
    );

    assign desc_rdata = mem[desc_addr];

    always @(posedge clk) begin
        if (desc_rd) begin
            rd_cnt[desc_addr] <= rd_cnt[desc_addr] + 1;
            if (late_en && desc_addr == late_idx) begin
                mem[desc_addr][31] <= 1'b1;
                late_en <= 1'b0;
            end
        end
        if (desc_we) begin
            wr_cnt <= wr_cnt + 1;
            if (desc_own_only) mem[desc_addr][31] <= desc_wdata[31];
            else               mem[desc_addr]     <= desc_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 16; i++) rd_cnt[i] = 0;
        wr_cnt = 0;
    endtask

    task automatic do_reset(input logic [IDX_W:0] rl, input logic [LEN_W-1:0] bl);
        @(negedge clk);
        rst_n = 1'b0;
        ring_len = rl;
        buf_len = bl;
        fifo_avail = 1'b0;
        fifo_last = 1'b0;
        miss_clr = 1'b0;
        late_en = 1'b0;
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (2) @(negedge clk);
        clear_log();
        rst_n = 1'b1;
    endtask

    task automatic send_frame(input int n, input bit gap);
        int k = 0;
        int guard = 0;
        int cyc = 0;
        while (k < n && guard < 500) begin
            @(negedge clk);
            fifo_avail = gap ? cyc[0] : 1'b1;
            fifo_last  = (k == n - 1);
            #1;
            if (fifo_pop && !fifo_avail) bad_pop++;
            if (fifo_pop) k++;
            guard++;
            cyc++;
        end
        @(negedge clk);
        fifo_avail = 1'b0;
        fifo_last  = 1'b0;
        if (k != n) chk("R12 frame fully popped", k, n);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(5'd4, 8'd4);
        repeat (3) @(negedge clk);
        chk("R1 miss_count at reset", 32'(miss_count), 0);
        chk("R1 miss_flag at reset", 32'(miss_flag), 0);
        chk("R1 no pop idle", 32'(fifo_pop), 0);
        chk("R1 no access idle", rd_cnt[0] + wr_cnt, 0);
    endtask

    task automatic t_normal();
        do_reset(5'd4, 8'd8);
        mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000; mem[2] = 32'h8000_0000;
        send_frame(5, 1'b0);
        settle();
        chk("R1 R4 first frame closes idx0", mem[0], 32'h4000_0005);
        chk("R4 next still owned", mem[1], 32'h8000_0000);
        bad_pop = 0;
        send_frame(3, 1'b1);
        settle();
        chk("R4 second frame at idx1", mem[1], 32'h4000_0003);
        chk("R12 no pop without data", bad_pop, 0);
    endtask

    task automatic t_final_poll();
        do_reset(5'd4, 8'd8);
        mem[1] = 32'h8000_0000;
        late_idx = 4'd0;
        late_en = 1'b1;
        send_frame(3, 1'b0);
        settle();
        chk("R2 frame kept after final poll", mem[0], 32'h4000_0003);
        chk("R2 two reads of current", rd_cnt[0], 2);
        chk("R2 no miss counted", 32'(miss_count), 0);
    endtask

    task automatic t_miss();
        do_reset(5'd4, 8'd8);
        send_frame(6, 1'b0);
        settle();
        chk("R3 miss counted", 32'(miss_count), 1);
        chk("R3 miss flag", 32'(miss_flag), 1);
        chk("R3 exactly two polls", rd_cnt[0], 2);
        chk("R3 no writes", wr_cnt, 0);
        mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000;
        send_frame(2, 1'b0);
        settle();
        chk("R3 index kept after miss", mem[0], 32'h4000_0002);
    endtask

    task automatic t_saturate_clear();
        do_reset(5'd4, 8'd8);
        for (int f = 0; f < 17; f++) send_frame(1, 1'b0);
        settle();
        chk("R9 counter saturates", 32'(miss_count), 15);
        @(negedge clk);
        miss_clr = 1'b1;
        @(negedge clk);
        miss_clr = 1'b0;
        chk("R10 count cleared", 32'(miss_count), 0);
        chk("R10 flag cleared", 32'(miss_flag), 0);
    endtask

    task automatic t_chain();
        do_reset(5'd4, 8'd4);
        mem[0] = 32'h8000_0ABC; mem[1] = 32'h8000_0000; mem[2] = 32'h8000_0000;
        send_frame(10, 1'b0);
        settle();
        chk("R5 first buffer own-only release", mem[0], 32'h0000_0ABC);
        chk("R5 second buffer released", mem[1], 32'h0000_0000);
        chk("R5 close on third with total", mem[2], 32'h4000_000A);
        chk("R5 lookahead read of idx3", rd_cnt[3], 1);
        chk("R5 idx3 untouched", mem[3], 32'h0000_0000);
    endtask

    task automatic t_cache();
        do_reset(5'd4, 8'd4);
        for (int i = 0; i < 4; i++) mem[i] = 32'h8000_0000;
        send_frame(6, 1'b0);
        settle();
        chk("R8 chained close at idx1", mem[1], 32'h4000_0006);
        send_frame(2, 1'b0);
        settle();
        chk("R8 frame at cached idx2", mem[2], 32'h4000_0002);
        chk("R8 idx2 read only once", rd_cnt[2], 1);
        chk("R8 idx3 polled once", rd_cnt[3], 1);
    endtask

    task automatic t_no_next();
        do_reset(5'd4, 8'd4);
        mem[0] = 32'h8000_0000;
        send_frame(7, 1'b0);
        settle();
        chk("R6 buffer and overflow error", mem[0], 32'h3000_0004);
        chk("R6 one write", wr_cnt, 1);
        mem[1] = 32'h8000_0000; mem[2] = 32'h8000_0000;
        send_frame(2, 1'b0);
        settle();
        chk("R6 index advanced", mem[1], 32'h4000_0002);
    endtask

    task automatic t_single();
        do_reset(5'd1, 8'd4);
        mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000;
        send_frame(3, 1'b0);
        settle();
        chk("R7 single entry close", mem[0], 32'h4000_0003);
        mem[0] = 32'h8000_0000;
        send_frame(6, 1'b0);
        settle();
        chk("R7 single entry overflow", mem[0], 32'h3000_0004);
        chk("R7 idx1 never read", rd_cnt[1], 0);
        chk("R7 idx1 untouched", mem[1], 32'h8000_0000);
    endtask

    task automatic t_wrap();
        do_reset(5'd2, 8'd8);
        mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000;
        send_frame(1, 1'b0);
        settle();
        send_frame(2, 1'b0);
        settle();
        chk("R11 idx1 used", mem[1], 32'h4000_0002);
        mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000;
        send_frame(3, 1'b0);
        settle();
        chk("R11 wraps to idx0", mem[0], 32'h4000_0003);
        chk("R11 idx2 never read", rd_cnt[2], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_final_poll();
        t_miss();
        t_saturate_clear();
        t_chain();
        t_cache();
        t_no_next();
        t_single();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule